// File: doc/BRIEF.md
# Micro-tiled surface address generator

This unit converts a texel coordinate into a bit address inside a texture surface whose storage is cut into square tiles of 8x8 elements. A tile is either one slice deep (thin) or four slices deep (thick). A one-cycle start pulse captures a complete surface description: the surface kind, the bits per fragment, whether the format is block compressed, whether dimensions are padded to powers of two, the mip level, the array index, the fragment count exponent, the level-0 width, the height, the depth, the pitch, and the x/y/z coordinate.

After capture the unit walks the mip chain one level at a time. For each level it derives padded and aligned dimensions. It widens the row pitch in steps of 8 elements until the physical slice size is a multiple of the 256-byte interleave. It then adds the size of all array slices of the previous level to a running base. Once the requested level is reached, it adds the array offset and the position of the element inside the level, raises `done`, and holds the result until the next start. A block-compressed format with an unsupported fragment size sets the error flag instead.

Top module: `mtile_addr_gen`

## Requirements
- R1: `start_i` is accepted only when `busy_o` is low; a pulse while busy is ignored, and the in-flight result is the one from the earlier capture.
- R2: Out of reset `busy_o`, `done_o`, `err_o` and `addr_o` are 0. The cycle after an accepted start `done_o` is 0. Once `done_o` rises it stays 1, and `addr_o` and `err_o` hold their values until the next accepted start, whatever the other inputs do.
- R3: With `thick_i`=1 a tile spans 4 slices, otherwise 1. Inside a tile the element index is (z mod depth)*64 + (y mod 8)*8 + (x mod 8).
- R4: `kind_i` encodes 0 = plain/array, 1 = cube, 2 = volume, 3 = treated as plain. The per-level slice multiplier is depth*6 for a cube, 1 for a volume, and depth otherwise. Only a volume uses the depth (shifted by the level) as the level's element depth; every other kind uses 1.
- R5: With `bc_i`=1 and 1 bit per fragment, the element size is 8 bits and widths are divided by 8, rounding up. With 4 or 8 bits per fragment, the element size is 16 times the fragment size and both width and height are divided by 4, rounding up. Any other size gives `err_o`=1 and `addr_o`=0.
- R6: Level 0 takes its width from `width_i`. Level i>0 takes it from `pitch_i`>>i. Height is `height_i`>>i. Each dimension is clamped to at least 1.
- R7: With `pow2_i`=1, the slice multiplier and each level's width, height and depth are rounded up to a power of two.
- R8: Each level's width and height are aligned up to 8 and its depth to the tile depth. The pitch then grows by 8 until (pitch*height*element bits*2^`frag_exp_i`/8, rounded up)*tile depth is a multiple of 256. The level size is that byte count times the aligned depth.
- R9: The base grows by the slice multiplier times the previous level's size at each level up to the requested one. The requested level's size times `slice_i` is then added.
- R10: With a tile size of 64*tile depth*element bits/8 bytes, tiles per row equal to the padded width/8, and tiles per slice equal to max(tiles per row*(padded height/8),1), the address is ((z/tile depth)*tiles per slice*tile size + ((y/8)*tiles per row + x/8)*tile size)*8 + element index*element bits + base*8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture request |
| kind_i | input | 2 | Surface kind (R4) |
| bpf_i | input | BPF_W | Bits per fragment |
| bc_i | input | 1 | Block-compressed format |
| pow2_i | input | 1 | Power-of-two padding |
| thick_i | input | 1 | Four-slice tiles |
| mip_i | input | LVL_W | Requested mip level |
| slice_i | input | SL_W | Array slice index |
| frag_exp_i | input | 2 | Log2 of fragments per pixel |
| width_i | input | DIM_W | Level-0 width |
| height_i | input | DIM_W | Level-0 height |
| depth_i | input | DIM_W | Depth or array size |
| pitch_i | input | DIM_W | Row pitch used from level 1 on |
| x_i | input | DIM_W | Element column |
| y_i | input | DIM_W | Element row |
| z_i | input | DIM_W | Element slice |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | Result valid and held |
| err_o | output | 1 | Unsupported compressed format |
| addr_o | output | 64 | Bit address |

## Verification
A single-level thin surface with a coordinate off the tile grid isolates the tile and element terms. A thick volume separates the z split between tile depth and slice offset. Deeper mip levels with a pitch unlike the width, cube and volume kinds with array indices, and the reserved kind distinguish the base accumulation and the slice multiplier. Each compressed fragment size, the rejected size, power-of-two padding and several fragment counts exercise the pitch widening under different divisibility. A start during a computation and input changes while the result is held show whether capture and hold behave.

// File: rtl/mtile_pkg.sv
package mtile_pkg;

  typedef enum logic [1:0] {
    KIND_PLAIN  = 2'd0,
    KIND_CUBE   = 2'd1,
    KIND_VOLUME = 2'd2,
    KIND_RSVD   = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEVEL = 3'd1,
    ST_PITCH = 3'd2,
    ST_FINAL = 3'd3,
    ST_DONE  = 3'd4
  } state_e;

  // Smallest power of two not below v; 0 and 1 both map to 1.
  function automatic logic [31:0] ceil_p2(input logic [31:0] v);
    logic [31:0] t;
    t = v - 32'd1;
    t = t | (t >> 1);
    t = t | (t >> 2);
    t = t | (t >> 4);
    t = t | (t >> 8);
    t = t | (t >> 16);
    return (v <= 32'd1) ? 32'd1 : t + 32'd1;
  endfunction

  // Compressed formats accept only 1, 4 or 8 bits per fragment.
  function automatic logic fmt_ok(input logic [7:0] bpf, input logic bc);
    return !bc || (bpf == 8'd1) || (bpf == 8'd4) || (bpf == 8'd8);
  endfunction

endpackage

// File: rtl/mtile_level_dims.sv
module mtile_level_dims
  import mtile_pkg::*;
#(
  parameter int DIM_W    = 14,
  parameter int LVL_W    = 4,
  parameter int BPF_W    = 8,
  parameter int MT_LOG2  = 3,
  parameter int THK_LOG2 = 2,
  parameter int XW       = DIM_W + 2
) (
  input  logic [LVL_W-1:0] lvl_i,
  input  kind_e            kind_i,
  input  logic [BPF_W-1:0] bpf_i,
  input  logic             bc_i,
  input  logic             pow2_i,
  input  logic             thick_i,
  input  logic [DIM_W-1:0] width_i,
  input  logic [DIM_W-1:0] height_i,
  input  logic [DIM_W-1:0] depth_i,
  input  logic [DIM_W-1:0] pitch_i,
  output logic [XW-1:0]    pad_w_o,
  output logic [XW-1:0]    pad_h_o,
  output logic [XW-1:0]    al_w_o,
  output logic [XW-1:0]    al_h_o,
  output logic [XW-1:0]    al_d_o
);

  localparam logic [XW-1:0] MT_MASK  = XW'((1 << MT_LOG2) - 1);
  localparam logic [XW-1:0] THK_MASK = XW'((1 << THK_LOG2) - 1);

  logic [DIM_W-1:0] src_w;
  logic [DIM_W-1:0] src_d;
  logic [XW-1:0]    w0, h0, d0;

  always_comb begin
    src_w = (lvl_i != '0) ? pitch_i : width_i;
    src_d = (kind_i == KIND_VOLUME) ? depth_i : DIM_W'(1);
    w0 = XW'(src_w >> lvl_i);
    h0 = XW'(height_i >> lvl_i);
    d0 = XW'(src_d >> lvl_i);
    if (w0 == '0) w0 = XW'(1);
    if (h0 == '0) h0 = XW'(1);
    if (d0 == '0) d0 = XW'(1);
    // compressed blocks shrink the element grid
    if (bc_i) begin
      if (bpf_i == BPF_W'(1)) begin
        w0 = (w0 + XW'(7)) >> 3;
      end else if ((bpf_i == BPF_W'(4)) || (bpf_i == BPF_W'(8))) begin
        w0 = (w0 + XW'(3)) >> 2;
        h0 = (h0 + XW'(3)) >> 2;
      end
    end
    if (pow2_i) begin
      w0 = XW'(ceil_p2(32'(w0)));
      h0 = XW'(ceil_p2(32'(h0)));
      d0 = XW'(ceil_p2(32'(d0)));
    end
    pad_w_o = w0;
    pad_h_o = h0;
    al_w_o  = (w0 + MT_MASK) & ~MT_MASK;
    al_h_o  = (h0 + MT_MASK) & ~MT_MASK;
    al_d_o  = thick_i ? ((d0 + THK_MASK) & ~THK_MASK) : d0;
  end

endmodule

// File: rtl/mtile_slice_bytes.sv
module mtile_slice_bytes #(
  parameter int XW       = 16,
  parameter int TPW      = 22,
  parameter int EB_W     = 12,
  parameter int FE_W     = 2,
  parameter int THK_LOG2 = 2,
  parameter int PI_LOG2  = 8
) (
  input  logic [TPW-1:0]  pitch_i,
  input  logic [XW-1:0]   height_i,
  input  logic [EB_W-1:0] ebits_i,
  input  logic [FE_W-1:0] frag_exp_i,
  input  logic            thick_i,
  output logic [63:0]     logical_o,
  output logic            fits_o
);

  localparam logic [63:0] PI_MASK = 64'((64'd1 << PI_LOG2) - 64'd1);

  logic [63:0] bits;
  logic [63:0] phys;

  always_comb begin
    bits      = (64'(pitch_i) * 64'(height_i) * 64'(ebits_i)) << frag_exp_i;
    logical_o = (bits + 64'd7) >> 3;
    phys      = thick_i ? (logical_o << THK_LOG2) : logical_o;
    fits_o    = (phys & PI_MASK) == 64'd0;
  end

endmodule

// File: rtl/mtile_place.sv
module mtile_place #(
  parameter int DIM_W    = 14,
  parameter int XW       = 16,
  parameter int EB_W     = 12,
  parameter int SL_W     = 11,
  parameter int MT_LOG2  = 3,
  parameter int THK_LOG2 = 2
) (
  input  logic [DIM_W-1:0] x_i,
  input  logic [DIM_W-1:0] y_i,
  input  logic [DIM_W-1:0] z_i,
  input  logic [XW-1:0]    pad_w_i,
  input  logic [XW-1:0]    pad_h_i,
  input  logic [EB_W-1:0]  ebits_i,
  input  logic             thick_i,
  input  logic [63:0]      base_i,
  input  logic [63:0]      lvl_size_i,
  input  logic [SL_W-1:0]  slice_i,
  output logic [63:0]      addr_o
);

  localparam logic [DIM_W-1:0] MT_MASK  = DIM_W'((1 << MT_LOG2) - 1);
  localparam logic [DIM_W-1:0] THK_MASK = DIM_W'((1 << THK_LOG2) - 1);

  logic [63:0] per_row, per_slice, tile_b, elem_idx, slice_off, tile_off, base_all;
  logic [63:0] zt, zm;

  always_comb begin
    per_row   = 64'(pad_w_i >> MT_LOG2);
    per_slice = per_row * 64'(pad_h_i >> MT_LOG2);
    if (per_slice == 64'd0) per_slice = 64'd1;
    tile_b    = (64'(ebits_i) << (2 * MT_LOG2 + (thick_i ? THK_LOG2 : 0))) >> 3;
    zt        = thick_i ? 64'(z_i >> THK_LOG2) : 64'(z_i);
    zm        = thick_i ? 64'(z_i & THK_MASK) : 64'd0;
    elem_idx  = (zm << (2 * MT_LOG2)) + (64'(y_i & MT_MASK) << MT_LOG2) + 64'(x_i & MT_MASK);
    slice_off = zt * per_slice * tile_b;
    tile_off  = (64'(y_i >> MT_LOG2) * per_row + 64'(x_i >> MT_LOG2)) * tile_b;
    base_all  = base_i + lvl_size_i * 64'(slice_i);
    addr_o    = ((slice_off + tile_off) << 3) + elem_idx * 64'(ebits_i) + (base_all << 3);
  end

endmodule

// File: rtl/mtile_addr_gen.sv
module mtile_addr_gen
  import mtile_pkg::*;
#(
  parameter int DIM_W    = 14,
  parameter int BPF_W    = 8,
  parameter int LVL_W    = 4,
  parameter int SL_W     = 11,
  parameter int FE_W     = 2,
  parameter int MT_LOG2  = 3,
  parameter int THK_LOG2 = 2,
  parameter int PI_LOG2  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       kind_i,
  input  logic [BPF_W-1:0] bpf_i,
  input  logic             bc_i,
  input  logic             pow2_i,
  input  logic             thick_i,
  input  logic [LVL_W-1:0] mip_i,
  input  logic [SL_W-1:0]  slice_i,
  input  logic [FE_W-1:0]  frag_exp_i,
  input  logic [DIM_W-1:0] width_i,
  input  logic [DIM_W-1:0] height_i,
  input  logic [DIM_W-1:0] depth_i,
  input  logic [DIM_W-1:0] pitch_i,
  input  logic [DIM_W-1:0] x_i,
  input  logic [DIM_W-1:0] y_i,
  input  logic [DIM_W-1:0] z_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [63:0]      addr_o
);

  localparam int XW   = DIM_W + 2;
  localparam int TPW  = XW + 6;
  localparam int EB_W = BPF_W + 4;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  // captured description
  kind_e            kind_q;
  logic [BPF_W-1:0] bpf_q;
  logic             bc_q, p2_q, thk_q;
  logic [LVL_W-1:0] mip_q;
  logic [SL_W-1:0]  sl_q;
  logic [FE_W-1:0]  fe_q;
  logic [DIM_W-1:0] w_q, h_q, d_q, p_q, x_q, y_q, z_q;

  state_e           state_q, state_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [63:0]      base_q, base_d, size_q, size_d, addr_q, addr_d;
  logic [TPW-1:0]   tp_q, tp_d;
  logic [XW-1:0]    eh_q, eh_d, ed_q, ed_d, pw_q, pw_d, ph_q, ph_d;
  logic             err_q, err_d, done_q, done_d, load;

  logic             accept, in_ok;
  logic [EB_W-1:0]  ebits;
  logic [31:0]      sc_raw, scount;
  logic [XW-1:0]    dm_pw, dm_ph, dm_w, dm_h, dm_d;
  logic [63:0]      logical, place_addr;
  logic             fits;

  assign accept = start_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));
  assign in_ok  = fmt_ok(8'(bpf_i), bc_i);

  always_comb begin
    if (!bc_q)                  ebits = EB_W'(bpf_q);
    else if (bpf_q == BPF_W'(1)) ebits = EB_W'(bpf_q) << 3;
    else                        ebits = EB_W'(bpf_q) << 4;
    case (kind_q)
      KIND_CUBE:   sc_raw = 32'(d_q) * 32'd6;
      KIND_VOLUME: sc_raw = 32'd1;
      default:     sc_raw = 32'(d_q);
    endcase
    scount = p2_q ? ceil_p2(sc_raw) : sc_raw;
  end

  mtile_level_dims #(
    .DIM_W(DIM_W), .LVL_W(LVL_W), .BPF_W(BPF_W),
    .MT_LOG2(MT_LOG2), .THK_LOG2(THK_LOG2), .XW(XW)
  ) dims_i (
    .lvl_i(lvl_q), .kind_i(kind_q), .bpf_i(bpf_q), .bc_i(bc_q),
    .pow2_i(p2_q), .thick_i(thk_q),
    .width_i(w_q), .height_i(h_q), .depth_i(d_q), .pitch_i(p_q),
    .pad_w_o(dm_pw), .pad_h_o(dm_ph),
    .al_w_o(dm_w), .al_h_o(dm_h), .al_d_o(dm_d)
  );

  mtile_slice_bytes #(
    .XW(XW), .TPW(TPW), .EB_W(EB_W), .FE_W(FE_W),
    .THK_LOG2(THK_LOG2), .PI_LOG2(PI_LOG2)
  ) slice_i_u (
    .pitch_i(tp_q), .height_i(eh_q), .ebits_i(ebits),
    .frag_exp_i(fe_q), .thick_i(thk_q),
    .logical_o(logical), .fits_o(fits)
  );

  mtile_place #(
    .DIM_W(DIM_W), .XW(XW), .EB_W(EB_W), .SL_W(SL_W),
    .MT_LOG2(MT_LOG2), .THK_LOG2(THK_LOG2)
  ) place_i (
    .x_i(x_q), .y_i(y_q), .z_i(z_q),
    .pad_w_i(pw_q), .pad_h_i(ph_q), .ebits_i(ebits), .thick_i(thk_q),
    .base_i(base_q), .lvl_size_i(size_q), .slice_i(sl_q),
    .addr_o(place_addr)
  );

  // next state
  always_comb begin
    state_d = state_q;
    lvl_d   = lvl_q;
    base_d  = base_q;
    size_d  = size_q;
    tp_d    = tp_q;
    eh_d    = eh_q;
    ed_d    = ed_q;
    pw_d    = pw_q;
    ph_d    = ph_q;
    addr_d  = addr_q;
    err_d   = err_q;
    done_d  = done_q;
    load    = 1'b0;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (accept) begin
          load    = 1'b1;
          lvl_d   = '0;
          base_d  = '0;
          size_d  = '0;
          addr_d  = '0;
          done_d  = 1'b0;
          err_d   = !in_ok;
          state_d = in_ok ? ST_LEVEL : ST_FINAL;
        end
      end
      ST_LEVEL: begin
        base_d  = base_q + 64'(scount) * size_q;
        tp_d    = TPW'(dm_w);
        eh_d    = dm_h;
        ed_d    = dm_d;
        pw_d    = dm_pw;
        ph_d    = dm_ph;
        state_d = ST_PITCH;
      end
      ST_PITCH: begin
        if (fits) begin
          size_d = logical * 64'(ed_q);
          if (lvl_q == mip_q) begin
            state_d = ST_FINAL;
          end else begin
            lvl_d   = lvl_q + LVL_W'(1);
            state_d = ST_LEVEL;
          end
        end else begin
          tp_d = tp_q + TPW'(1 << MT_LOG2);
        end
      end
      ST_FINAL: begin
        addr_d  = err_q ? 64'd0 : place_addr;
        done_d  = 1'b1;
        state_d = ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // working registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
      base_q  <= '0;
      size_q  <= '0;
      tp_q    <= '0;
      eh_q    <= '0;
      ed_q    <= '0;
      pw_q    <= '0;
      ph_q    <= '0;
      addr_q  <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      lvl_q   <= lvl_d;
      base_q  <= base_d;
      size_q  <= size_d;
      tp_q    <= tp_d;
      eh_q    <= eh_d;
      ed_q    <= ed_d;
      pw_q    <= pw_d;
      ph_q    <= ph_d;
      addr_q  <= addr_d;
      err_q   <= err_d;
      done_q  <= done_d;
    end
  end

  // description capture, enabled by an accepted start
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      kind_q <= KIND_PLAIN;
      bpf_q  <= '0;
      bc_q   <= 1'b0;
      p2_q   <= 1'b0;
      thk_q  <= 1'b0;
      mip_q  <= '0;
      sl_q   <= '0;
      fe_q   <= '0;
      w_q    <= '0;
      h_q    <= '0;
      d_q    <= '0;
      p_q    <= '0;
      x_q    <= '0;
      y_q    <= '0;
      z_q    <= '0;
    end else if (load) begin
      kind_q <= kind_e'(kind_i);
      bpf_q  <= bpf_i;
      bc_q   <= bc_i;
      p2_q   <= pow2_i;
      thk_q  <= thick_i;
      mip_q  <= mip_i;
      sl_q   <= slice_i;
      fe_q   <= frag_exp_i;
      w_q    <= width_i;
      h_q    <= height_i;
      d_q    <= depth_i;
      p_q    <= pitch_i;
      x_q    <= x_i;
      y_q    <= y_i;
      z_q    <= z_i;
    end
  end

  assign busy_o = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done_o = done_q;
  assign err_o  = err_q;
  assign addr_o = addr_q;

  // R1: an accepted start withdraws the previous result
  a_r1_accept_clears: assert property (@(posedge clk) disable iff (!rst_s)
    (start_i && !busy_o) |=> !done_o);

  // R2: a finished result holds until the next start
  a_r2_result_hold: assert property (@(posedge clk) disable iff (!rst_s)
    (done_o && !start_i) |=> (done_o && $stable(addr_o) && $stable(err_o)));

  // R5: a rejected format reports a zero address
  a_r5_err_zero: assert property (@(posedge clk) disable iff (!rst_s)
    (done_o && err_o) |-> (addr_o == 64'd0));

  // R8: each failed interleave check widens the pitch by one tile
  a_r8_pitch_step: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_PITCH && !fits) |=> (tp_q == $past(tp_q) + TPW'(1 << MT_LOG2)));

  // R9: the running base never shrinks during a level walk
  a_r9_base_grows: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_LEVEL) |=> (base_q >= $past(base_q)));

  // R6: the level counter never passes the requested level
  a_r6_level_bound: assert property (@(posedge clk) disable iff (!rst_s)
    busy_o |-> (lvl_q <= mip_q));

endmodule

// File: tb/mtile_addr_gen_tb.sv
module mtile_addr_gen_tb_top;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [1:0]  kind;
  logic [7:0]  bpf;
  logic        bc, p2, thk;
  logic [3:0]  mip;
  logic [10:0] sl;
  logic [1:0]  fe;
  logic [13:0] w, h, d, p, x, y, z;
  logic        busy, done, err;
  logic [63:0] addr;

  int total = 0;
  int bad   = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  mtile_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .kind_i(kind), .bpf_i(bpf),
    .bc_i(bc), .pow2_i(p2), .thick_i(thk), .mip_i(mip), .slice_i(sl),
    .frag_exp_i(fe), .width_i(w), .height_i(h), .depth_i(d), .pitch_i(p),
    .x_i(x), .y_i(y), .z_i(z), .busy_o(busy), .done_o(done), .err_o(err),
    .addr_o(addr)
  );

  function automatic longint unsigned cp2(longint unsigned v);
    longint unsigned r = 1;
    while (r < v) r = r << 1;
    return r;
  endfunction

  // behavioural reference built from the requirement text
  function automatic longint unsigned ref_addr(
      int kd, int fb, int c, int pp, int tk, int lv, int si, int fx,
      int sw, int sh, int sd, int sp, int cx, int cy, int cz, output bit e);
    longint unsigned th, sc, eb, base, size, ew, eh, ed, tp, lg, pw, ph;
    longint unsigned tpr, tps, tb, ei;
    e = 0; pw = 1; ph = 1;
    th = tk ? 4 : 1;
    sc = (kd == 1) ? sd * 6 : (kd == 2) ? 1 : sd;
    if (pp != 0) sc = cp2(sc);
    eb = fb;
    if (c != 0) begin
      if (fb == 1) eb = 8;
      else if (fb == 4 || fb == 8) eb = fb * 16;
      else begin e = 1; return 0; end
    end
    base = 0; size = 0;
    for (int i = 0; i <= lv; i++) begin
      base += sc * size;
      ew = (i > 0 ? sp : sw) >> i; if (ew == 0) ew = 1;
      eh = sh >> i;                if (eh == 0) eh = 1;
      ed = (kd == 2 ? sd : 1) >> i; if (ed == 0) ed = 1;
      if (c != 0) begin
        if (fb == 1) ew = (ew + 7) / 8;
        else begin ew = (ew + 3) / 4; eh = (eh + 3) / 4; end
      end
      if (pp != 0) begin ew = cp2(ew); eh = cp2(eh); ed = cp2(ed); end
      pw = ew; ph = eh;
      ew = (ew + 7) / 8 * 8;
      eh = (eh + 7) / 8 * 8;
      ed = (ed + th - 1) / th * th;
      tp = ew;
      lg = (tp * eh * eb * (64'd1 << fx) + 7) / 8;
      while (((lg * th) % 256) != 0) begin
        tp += 8;
        lg = (tp * eh * eb * (64'd1 << fx) + 7) / 8;
      end
      size = lg * ed;
    end
    base += size * si;
    tpr = pw / 8;
    tps = tpr * (ph / 8); if (tps == 0) tps = 1;
    tb  = (64 * th * eb + 7) / 8;
    ei  = (cz % th) * 64 + (cy % 8) * 8 + (cx % 8);
    return ((cz / th) * tps * tb + ((cy / 8) * tpr + cx / 8) * tb) * 8 + ei * eb + base * 8;
  endfunction

  task automatic chk(string req, string what, longint unsigned act, longint unsigned exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic setin(int kd, int fb, int c, int pp, int tk, int lv, int si, int fx,
                       int sw, int sh, int sd, int sp, int cx, int cy, int cz);
    kind = 2'(kd); bpf = 8'(fb); bc = c[0]; p2 = pp[0]; thk = tk[0];
    mip = 4'(lv); sl = 11'(si); fe = 2'(fx);
    w = 14'(sw); h = 14'(sh); d = 14'(sd); p = 14'(sp);
    x = 14'(cx); y = 14'(cy); z = 14'(cz);
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
  endtask

  // capture, wait, then compare the held result on three clocks
  task automatic run(string req, int kd, int fb, int c, int pp, int tk, int lv, int si,
                     int fx, int sw, int sh, int sd, int sp, int cx, int cy, int cz);
    bit e;
    longint unsigned ex;
    ex = ref_addr(kd, fb, c, pp, tk, lv, si, fx, sw, sh, sd, sp, cx, cy, cz, e);
    @(negedge clk);
    setin(kd, fb, c, pp, tk, lv, si, fx, sw, sh, sd, sp, cx, cy, cz);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2", "done low after capture", 64'(done), 0);
    wait_done();
    for (int k = 0; k < 3; k++) begin
      chk(req, "address", addr, ex);
      chk(req, "error flag", 64'(err), 64'(e));
      chk("R2", "done held", 64'(done), 1);
      x = x + 14'd1;   // a changing input must not disturb the held result
      @(negedge clk);
    end
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    bad++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit e;
    longint unsigned ex;
    rst_n = 1'b0; start = 1'b0;
    setin(0, 32, 0, 0, 0, 0, 0, 0, 64, 64, 1, 64, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2", "reset busy", 64'(busy), 0);
    chk("R2", "reset done", 64'(done), 0);
    chk("R2", "reset err", 64'(err), 0);
    chk("R2", "reset addr", addr, 0);

    // R10: thin single level, coordinate off the tile grid
    run("R10", 0, 32, 0, 0, 0, 0, 0, 0, 64, 64, 1, 64, 13, 21, 0);
    // R3: thick volume, z splits into tile slice and in-tile slice
    run("R3", 2, 32, 0, 0, 1, 0, 0, 0, 32, 32, 16, 32, 5, 9, 6);
    // R6: deeper level uses the pitch, not the width
    run("R6", 0, 16, 0, 0, 0, 2, 0, 0, 100, 60, 1, 128, 3, 4, 0);
    // R6: small level clamps to 1
    run("R6", 0, 32, 0, 0, 0, 5, 0, 0, 16, 8, 1, 16, 0, 0, 0);
    // R4: cube with array slice
    run("R4", 1, 32, 0, 0, 0, 1, 3, 0, 16, 16, 1, 16, 2, 3, 0);
    // R4: volume over mip levels
    run("R4", 2, 32, 0, 0, 1, 2, 0, 0, 64, 64, 16, 64, 1, 2, 1);
    // R4: reserved kind acts as plain
    run("R4", 3, 32, 0, 0, 0, 1, 2, 0, 40, 24, 5, 48, 7, 7, 0);
    // R5: the three compressed sizes
    run("R5", 0, 1, 1, 0, 0, 1, 0, 0, 64, 32, 1, 64, 3, 5, 0);
    run("R5", 0, 4, 1, 0, 0, 1, 1, 0, 128, 64, 2, 128, 9, 2, 0);
    run("R5", 0, 8, 1, 0, 0, 0, 0, 0, 60, 36, 1, 60, 10, 11, 0);
    // R5: unsupported compressed size
    run("R5", 0, 16, 1, 0, 0, 1, 0, 0, 64, 64, 1, 64, 1, 1, 0);
    // R7: power-of-two padding of slices and dimensions
    run("R7", 1, 32, 0, 1, 0, 1, 4, 0, 100, 50, 3, 104, 6, 9, 0);
    // R8: pitch widening with fragments and odd sizes
    run("R8", 0, 8, 0, 0, 0, 0, 0, 2, 24, 8, 1, 24, 17, 3, 0);
    run("R8", 0, 8, 0, 0, 1, 1, 0, 0, 24, 40, 1, 40, 5, 5, 0);
    // R9: array slice after three levels
    run("R9", 0, 16, 0, 0, 0, 3, 5, 1, 96, 80, 8, 96, 4, 6, 0);

    // R1: a second start while busy is ignored
    ex = ref_addr(0, 32, 0, 0, 0, 2, 1, 0, 64, 64, 2, 64, 9, 9, 0, e);
    @(negedge clk);
    setin(0, 32, 0, 0, 0, 2, 1, 0, 64, 64, 2, 64, 9, 9, 0);
    start = 1'b1;
    @(negedge clk);
    setin(1, 8, 0, 0, 0, 0, 0, 0, 8, 8, 1, 8, 1, 1, 0);
    chk("R1", "busy after capture", 64'(busy), 1);
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk("R1", "address after ignored start", addr, ex);
    chk("R1", "error after ignored start", 64'(err), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule